// File: doc/BRIEF.md
# Time-Sliced Gray-Code Pixel Hit Counter

This block is the digital counting stage of one pixel in a hit-counting pixel detector. A synchronized, single-cycle hit pulse from the pixel's discriminator advances an 8-bit Gray-code counter. Each beam train is cut into 16 consecutive time slices. A slice strobe closes the current slice: it files the running count into the next slot of a 16-entry bank and restarts the counter. The pixel therefore keeps a time profile of its hits across the train, not one total.

Between trains the bank is read through a small address port. The port returns the stored Gray value, its binary equivalent for test, and a per-slice flag. The flag marks a slice whose counter hit its ceiling and dropped hits.

A sequencer drives the block through three states:
- `ST_IDLE` is the state after reset. Readout is open.
- `ST_COUNT` is entered from any state on a train start. It holds while slices are closed. A further train start while in `ST_COUNT` restarts the train.
- `ST_DONE` is entered from `ST_COUNT` when the 16th slice strobe is taken. It is left only by a new train start.

Top module: `pixel_slice_counter`

## Requirements
- R1: After reset the block is in the gap (`rd_valid` = 1), and every one of the 16 slots reads 0 on `rd_gray`, `rd_bin` and `rd_ovf`.
- R2: A slice that saw n hits (n ≤ 255) stores the value n ^ (n >> 1), which is n in reflected binary Gray code, in slot k. Here k is the number of slice strobes taken since the train start.
- R3: The running count changes by exactly one bit per counted hit. Slices holding n and n+1 hits read back with a Hamming distance of 1.
- R4: A slice strobe and a hit in the same cycle credit that hit to the new slice: the new slice starts at 1.
- R5: The counter holds at the Gray code of 255 (binary 1000_0000) instead of wrapping. A hit that arrives while it is held sets that slice's `rd_ovf` flag. A slice with exactly 255 hits leaves the flag clear.
- R6: `train_start` clears all 16 slots, the counter and the slice index, in any state. A hit in the same cycle is not counted.
- R7: Once 16 slices are filled, further slice strobes and hits change no slot until the next `train_start`.
- R8: While counting (`ST_COUNT`), `rd_valid` is 0 and `rd_gray`, `rd_bin` and `rd_ovf` read 0. In `ST_IDLE` and `ST_DONE`, `rd_valid` is 1 and the slot at `rd_addr` is shown combinationally.
- R9: `rd_bin` is the binary value of `rd_gray`.
- R10: Hits on every clock cycle are all counted, with no loss, up to the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Single-cycle pulse: clear and begin a train |
| slice_advance | input | 1 | Single-cycle pulse: close the current slice |
| hit | input | 1 | Synchronized single-cycle hit pulse |
| rd_addr | input | 4 | Slot number to read |
| rd_valid | output | 1 | High while readout is open (between trains) |
| rd_gray | output | 8 | Stored count of the addressed slot, Gray coded |
| rd_bin | output | 8 | Stored count of the addressed slot, binary |
| rd_ovf | output | 1 | Lost-hit flag of the addressed slot |

## Verification
Trains are run with random hit densities from sparse to every cycle, and with random slice lengths. This separates a correct slot order and slice restart from off-by-one indexing and from misfiled counts.

Directed slices cover the following cases:
- Exactly 255 hits and 300 hits, which separate holding at the ceiling from wrapping, and a correct overflow flag from an early one.
- A strobe that coincides with a hit, which shows which slice is credited.
- Slices of n and n+1 hits, which expose non-Gray stepping.
- Restarts in the middle of a train and strobes after the 16th slice, which show that the index is cleared and that a full bank is frozen.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_SLICES = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pxc_gray_counter.sv
module pxc_gray_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load_one,
    input  logic         inc,
    output logic [W-1:0] gray_q,
    output logic         at_max,
    output logic         lost_hit
);
    logic [W-1:0] bin_cur;
    logic [W-1:0] bin_nxt;
    logic [W-1:0] gray_nxt;

    // Gray to binary: running XOR from the top bit down
    always_comb begin
        bin_cur[W-1] = gray_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_cur[i] = bin_cur[i+1] ^ gray_q[i];
        end
    end

    assign at_max   = &bin_cur;
    assign bin_nxt  = bin_cur + {{(W-1){1'b0}}, 1'b1};
    assign gray_nxt = bin_nxt ^ (bin_nxt >> 1);
    assign lost_hit = inc && at_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_q <= '0;
        end else if (clear) begin
            gray_q <= load_one ? {{(W-1){1'b0}}, 1'b1} : '0;
        end else if (inc && !at_max) begin
            gray_q <= gray_nxt;
        end
    end
endmodule

// File: rtl/pxc_slice_bank.sv
module pxc_slice_bank #(
    parameter int W  = 8,
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_ovf,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          rd_ovf
);
    logic [W-1:0] slot_val [N];
    logic         slot_ovf [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_val[g] <= '0;
                slot_ovf[g] <= 1'b0;
            end else if (wipe) begin
                slot_val[g] <= '0;
                slot_ovf[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slot_val[g] <= wr_data;
                slot_ovf[g] <= wr_ovf;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        rd_ovf  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = slot_val[i];
                rd_ovf  = slot_ovf[i];
            end
        end
    end
endmodule

// File: rtl/pxc_sequencer.sv
module pxc_sequencer #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                train_start,
    input  logic                slice_advance,
    output pxc_pkg::seq_state_t state,
    output logic                counting,
    output logic                rd_open,
    output logic                adv_take,
    output logic [IW-1:0]       slice_idx
);
    import pxc_pkg::*;

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    seq_state_t state_nxt;
    logic       last_slice;

    assign last_slice = (slice_idx == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (train_start) state_nxt = ST_COUNT;
            ST_COUNT: begin
                if (train_start)                      state_nxt = ST_COUNT;
                else if (slice_advance && last_slice) state_nxt = ST_DONE;
            end
            ST_DONE:  if (train_start) state_nxt = ST_COUNT;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        counting = 1'b0;
        rd_open  = 1'b0;
        adv_take = 1'b0;
        unique case (state)
            ST_IDLE:  rd_open = 1'b1;
            ST_COUNT: begin
                counting = 1'b1;
                adv_take = slice_advance && !train_start;
            end
            ST_DONE:  rd_open = 1'b1;
            default:  rd_open = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_idx <= '0;
        end else if (train_start) begin
            slice_idx <= '0;
        end else if (adv_take) begin
            slice_idx <= last_slice ? '0 : slice_idx + IW'(1);
        end
    end
endmodule

// File: rtl/pixel_slice_counter.sv
module pixel_slice_counter #(
    parameter int CNT_W  = pxc_pkg::DEF_CNT_W,
    parameter int SLICES = pxc_pkg::DEF_SLICES,
    parameter int IDX_W  = $clog2(SLICES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_start,
    input  logic             slice_advance,
    input  logic             hit,
    input  logic [IDX_W-1:0] rd_addr,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_gray,
    output logic [CNT_W-1:0] rd_bin,
    output logic             rd_ovf
);
    import pxc_pkg::*;

    seq_state_t       state;
    logic             counting;
    logic             rd_open;
    logic             adv_take;
    logic [IDX_W-1:0] slice_idx;
    logic [CNT_W-1:0] cnt_gray;
    logic             cnt_at_max;
    logic             lost_hit;
    logic             hit_take;
    logic             cnt_inc;
    logic             ovf_pend;
    logic [CNT_W-1:0] bank_data;
    logic             bank_ovf;

    pxc_sequencer #(.N(SLICES), .IW(IDX_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .train_start   (train_start),
        .slice_advance (slice_advance),
        .state         (state),
        .counting      (counting),
        .rd_open       (rd_open),
        .adv_take      (adv_take),
        .slice_idx     (slice_idx)
    );

    assign hit_take = hit && counting && !train_start;
    assign cnt_inc  = hit_take && !adv_take;

    pxc_gray_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (train_start || adv_take),
        .load_one (adv_take && hit_take),
        .inc      (cnt_inc),
        .gray_q   (cnt_gray),
        .at_max   (cnt_at_max),
        .lost_hit (lost_hit)
    );

    // sticky lost-hit marker for the open slice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_pend <= 1'b0;
        end else if (train_start || adv_take) begin
            ovf_pend <= 1'b0;
        end else if (lost_hit) begin
            ovf_pend <= 1'b1;
        end
    end

    pxc_slice_bank #(.W(CNT_W), .N(SLICES), .IW(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (train_start),
        .wr_en   (adv_take),
        .wr_idx  (slice_idx),
        .wr_data (cnt_gray),
        .wr_ovf  (ovf_pend),
        .rd_idx  (rd_addr),
        .rd_data (bank_data),
        .rd_ovf  (bank_ovf)
    );

    assign rd_valid = rd_open;
    assign rd_gray  = rd_open ? bank_data : '0;
    assign rd_ovf   = rd_open && bank_ovf;

    always_comb begin
        rd_bin[CNT_W-1] = rd_gray[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            rd_bin[i] = rd_bin[i+1] ^ rd_gray[i];
        end
    end
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
    parameter int W  = 8,
    parameter int IW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                train_start,
    input logic                slice_advance,
    input logic                hit,
    input pxc_pkg::seq_state_t state,
    input logic [W-1:0]        cnt_gray,
    input logic [IW-1:0]       slice_idx,
    input logic                rd_valid,
    input logic [W-1:0]        rd_gray,
    input logic                rd_ovf
);
    import pxc_pkg::*;

    localparam logic [W-1:0] GRAY_TOP = {1'b1, {(W-1){1'b0}}};

    p_one_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !train_start && !slice_advance)
        |=> ($countones(cnt_gray ^ $past(cnt_gray)) <= 1));

    p_adv_hit_new_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !train_start && slice_advance && hit)
        |=> (cnt_gray == {{(W-1){1'b0}}, 1'b1}));

    p_hold_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !train_start && !slice_advance && cnt_gray == GRAY_TOP)
        |=> (cnt_gray == GRAY_TOP));

    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> (cnt_gray == '0 && slice_idx == '0 && state == ST_COUNT));

    p_done_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !train_start) |=> (state == ST_DONE && $stable(slice_idx)));

    p_gap_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid == (state != ST_COUNT)) && (!rd_valid -> (rd_gray == '0 && !rd_ovf)));
endmodule

bind pixel_slice_counter pxc_checker #(.W(CNT_W), .IW(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .train_start   (train_start),
    .slice_advance (slice_advance),
    .hit           (hit),
    .state         (state),
    .cnt_gray      (cnt_gray),
    .slice_idx     (slice_idx),
    .rd_valid      (rd_valid),
    .rd_gray       (rd_gray),
    .rd_ovf        (rd_ovf)
);

// File: tb/pixel_slice_counter_test.sv
module pixel_slice_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       train_start = 1'b0;
    logic       slice_advance = 1'b0;
    logic       hit = 1'b0;
    logic [3:0] rd_addr = '0;
    logic       rd_valid;
    logic [7:0] rd_gray;
    logic [7:0] rd_bin;
    logic       rd_ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_state = 0;       // 0 gap after reset, 1 counting, 2 bank full
    int m_cur = 0;
    bit m_pend = 0;
    int m_idx = 0;
    int exp_cnt [NS];
    bit exp_ovf [NS];

    pixel_slice_counter uut (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .slice_advance(slice_advance), .hit(hit), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_gray(rd_gray), .rd_bin(rd_bin), .rd_ovf(rd_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] gray_of(input int n);
        logic [7:0] b;
        b = 8'(n);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_step(input bit h, input bit adv, input bit ts);
        if (ts) begin
            for (int i = 0; i < NS; i++) begin exp_cnt[i] = 0; exp_ovf[i] = 0; end
            m_cur = 0; m_pend = 0; m_idx = 0; m_state = 1;
        end else if (m_state == 1) begin
            if (adv) begin
                exp_cnt[m_idx] = m_cur;
                exp_ovf[m_idx] = m_pend;
                m_cur = h ? 1 : 0;
                m_pend = 0;
                m_idx++;
                if (m_idx == NS) m_state = 2;
            end else if (h) begin
                if (m_cur == 255) m_pend = 1;
                else m_cur++;
            end
        end
    endtask

    // one clock: inputs set at the falling edge, settled by the next falling edge
    task automatic cyc(input bit h, input bit adv, input bit ts);
        hit = h; slice_advance = adv; train_start = ts;
        @(posedge clk);
        @(negedge clk);
        model_step(h, adv, ts);
        hit = 0; slice_advance = 0; train_start = 0;
    endtask

    task automatic hits(input int n, input int dens);
        for (int i = 0; i < n; i++) cyc(($urandom % 100) < dens, 1'b0, 1'b0);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < NS; a++) begin
            rd_addr = 4'(a);
            #1;
            check(rd_gray == gray_of(exp_cnt[a]), {"R2 gray slot ", tag}, rd_gray, gray_of(exp_cnt[a]));
            check(rd_bin == 8'(exp_cnt[a]), {"R9 bin slot ", tag}, rd_bin, exp_cnt[a]);
            check(rd_ovf == exp_ovf[a], {"R5 ovf slot ", tag}, rd_ovf, exp_ovf[a]);
        end
    endtask

    task automatic random_train(input int dens);
        cyc(1'b0, 1'b0, 1'b1);
        for (int s = 0; s < NS; s++) begin
            hits(1 + ($urandom % 40), dens);
            cyc(($urandom % 100) < dens, 1'b1, 1'b0);
        end
        check(rd_valid == 1'b1, "R8 gap open after train", rd_valid, 1);
        read_all("random");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int g4;
        int g5;
        void'($urandom(32'd2718));
        for (int i = 0; i < NS; i++) begin exp_cnt[i] = 0; exp_ovf[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(rd_valid == 1'b1, "R1 gap after reset", rd_valid, 1);
        read_all("R1 reset");

        // directed train
        cyc(1'b1, 1'b0, 1'b1);                 // R6: hit with start not counted
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0);
        check(rd_valid == 1'b0, "R8 closed while counting", rd_valid, 0);
        rd_addr = 4'd0; #1;
        check(rd_gray == 8'd0 && rd_ovf == 1'b0, "R8 data masked while counting", rd_gray, 0);
        cyc(1'b1, 1'b1, 1'b0);                 // R4: strobe with hit
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);                 // slice1 = 3
        for (int i = 0; i < 255; i++) cyc(1'b1, 1'b0, 1'b0);   // R10 every cycle
        cyc(1'b0, 1'b1, 1'b0);                 // slice2 = 255, no flag
        for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);                 // slice3 held at 255, flag
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);                 // slice4 = 100
        for (int i = 0; i < 101; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);                 // slice5 = 101
        for (int s = 6; s < NS; s++) begin
            hits(1 + ($urandom % 20), 50);
            cyc(1'b0, 1'b1, 1'b0);
        end
        check(exp_cnt[0] == 5 && exp_cnt[1] == 3, "R4 model sanity", exp_cnt[1], 3);
        check(rd_valid == 1'b1, "R8 gap open when bank full", rd_valid, 1);
        read_all("directed");
        rd_addr = 4'd2; #1;
        check(rd_bin == 8'd255 && rd_ovf == 1'b0, "R5 exactly 255 no flag", rd_bin, 255);
        rd_addr = 4'd3; #1;
        check(rd_gray == 8'h80 && rd_ovf == 1'b1, "R5 held at top with flag", rd_gray, 8'h80);
        rd_addr = 4'd1; #1;
        check(rd_bin == 8'd3, "R4 coincident hit in new slice", rd_bin, 3);
        rd_addr = 4'd4; #1; g4 = rd_gray;
        rd_addr = 4'd5; #1; g5 = rd_gray;
        check($countones(8'(g4 ^ g5)) == 1, "R3 one bit between n and n+1", $countones(8'(g4 ^ g5)), 1);

        // R7: strobes and hits after the bank is full
        for (int i = 0; i < 20; i++) cyc(1'b1, i[0], 1'b0);
        check(rd_valid == 1'b1, "R7 stays in gap", rd_valid, 1);
        read_all("R7 frozen");

        // R6: restart in mid train
        cyc(1'b0, 1'b0, 1'b1);
        for (int s = 0; s < 5; s++) begin hits(10, 70); cyc(1'b1, 1'b1, 1'b0); end
        hits(7, 100);
        cyc(1'b1, 1'b0, 1'b1);
        for (int s = 0; s < NS; s++) begin
            hits(s + 1, 100);
            cyc(1'b0, 1'b1, 1'b0);
        end
        rd_addr = 4'd15; #1;
        check(rd_bin == 8'd16, "R6 index restarted", rd_bin, 16);
        read_all("R6 restart");

        // constrained random trains
        random_train(10);
        random_train(50);
        random_train(90);
        random_train(100);
        random_train(0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule